// File: doc/BRIEF.md
# Supply-Aware Operating Mode Controller

This block is the central mode sequencer of a power-management companion device. The device powers a host microcontroller from an on-chip regulator and carries a single-wire bus transceiver. The controller reads flags that are already digital: supply above its power-up level, supply below its power-down level, regulator output below its threshold, over-temperature and bus wakeup. It also reads two host pins, enable and transmit-data. From these it drives the regulator enable, an active-low reset to the host, the transceiver mode and a 3-bit mode code.

There are six modes. A power-loss state and a thermal state are entered by force. Every path back to operation goes through a timed Reset mode, in which the regulator stays powered while the host is held in reset. While Normal is active, the host picks a low-power mode as follows. It drops enable, which opens a selection window of fixed length. At the end of that window the level of transmit-data decides the outcome: high gives Standby, where the regulator stays on, and low gives Sleep, where the regulator is switched off. The host pins pass through two-flop synchronizers. The regulator undervoltage flag must stay asserted for a filter time before it takes effect.

Top module: `opmode_ctrl`

## Requirements
- R1: After the logic reset `rst_n` is released, the mode is Shutdown with the regulator off, the host reset low and the transceiver off. Mode codes are 0 Shutdown, 1 Reset, 2 Normal, 3 Standby, 4 Sleep and 5 Thermal. Transceiver codes are 0 off, 1 wakeup and 2 active.
- R2: While `sup_lo` is high, all outputs show Shutdown in the same cycle (mode 0, regulator off, reset low, transceiver off), whatever mode was active. The state register is Shutdown from the next clock edge on.
- R3: Shutdown is left only when `sup_hi` is high and `over_temp` is low. The mode then becomes Reset at the next edge. Over-temperature does not cause Thermal while in Shutdown.
- R4: `over_temp` high in any mode other than Shutdown gives Thermal at the next edge. Thermal has the regulator off, reset low and the transceiver in wakeup. When `over_temp` clears, the mode becomes Reset at the next edge.
- R5: Reset has the regulator on, reset low and the transceiver in wakeup. With `vout_uv` low it lasts exactly RST_CYC cycles. While `vout_uv` stays high it is extended for as long as needed.
- R6: Reset exits to Normal when the synchronized enable is high, and to Standby when it is low.
- R7: `en` and `txd` each pass through two flops. A change on `en` affects the mode at the third rising edge after it.
- R8: In Normal, synchronized enable low opens a selection window. The mode code stays 2, and the transceiver drops to wakeup at once. After SEL_CYC cycles, synchronized transmit-data is sampled: 1 gives Standby and 0 gives Sleep. Only the level at the end of the window counts.
- R9: Synchronized enable going high during the window ends it, returning to Normal with the transceiver active.
- R10: Normal has the regulator on, reset high and the transceiver active. Standby has the regulator on, reset high and the transceiver in wakeup. In Standby, synchronized enable high gives Normal.
- R11: Sleep has the regulator off, reset low and the transceiver in wakeup. `bus_wake` high, or synchronized enable high, gives Reset at the next edge. `vout_uv` has no effect in Sleep.
- R12: In Normal, Standby or the selection window, `vout_uv` high for UVF_CYC consecutive cycles gives Reset at the following edge. Shorter dips have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous logic reset |
| sup_hi | input | 1 | Supply is above the power-up level |
| sup_lo | input | 1 | Supply is below the power-down level |
| over_temp | input | 1 | Junction over-temperature flag |
| vout_uv | input | 1 | Regulator output is below its threshold (raw) |
| bus_wake | input | 1 | Valid bus wakeup seen by the transceiver |
| en | input | 1 | Host enable pin (asynchronous) |
| txd | input | 1 | Host transmit-data pin (asynchronous) |
| reg_en_o | output | 1 | Regulator enable |
| rst_out_n | output | 1 | Active-low reset to the host |
| xcvr_mode_o | output | 2 | Transceiver mode: 0 off, 1 wakeup, 2 active |
| mode_o | output | 3 | Current mode code |

## Verification
The bench measures the length of Reset to the exact cycle. A timer that is one cycle off moves the edge on which the host leaves reset. Reset must also be held while the regulator output stays low, or the host would be released on a dead supply. The bench changes transmit-data partway through the selection window, to catch a design that samples it at the start instead of at the end. It also raises enable again inside the window, where a design that ignores the abort would fall into Standby or Sleep. Undervoltage dips one cycle shorter than the filter, undervoltage in Sleep and over-temperature in Shutdown are all applied. A wrong filter length or wrong priority would send the controller into Reset or Thermal where it must not go.

// File: rtl/opmode_pkg.sv
package opmode_pkg;

  // Externally visible mode codes
  typedef enum logic [2:0] {
    MD_SHDN    = 3'd0,
    MD_RESET   = 3'd1,
    MD_NORMAL  = 3'd2,
    MD_STANDBY = 3'd3,
    MD_SLEEP   = 3'd4,
    MD_THERM   = 3'd5
  } mode_e;

  // Internal states: the selection window is a hidden sub-state of Normal
  typedef enum logic [2:0] {
    ST_SHDN    = 3'd0,
    ST_RESET   = 3'd1,
    ST_NORMAL  = 3'd2,
    ST_STANDBY = 3'd3,
    ST_SLEEP   = 3'd4,
    ST_THERM   = 3'd5,
    ST_SELECT  = 3'd6
  } state_e;

  typedef enum logic [1:0] {
    XC_OFF    = 2'd0,
    XC_WAKE   = 2'd1,
    XC_ACTIVE = 2'd2
  } xcvr_e;

  localparam int unsigned MODE_W = 3;
  localparam int unsigned XCVR_W = 2;

endpackage

// File: rtl/opmode_sync.sv
module opmode_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q <= '0;
        end else begin
          chain_q <= {chain_q[STAGES-2:0], async_i[b]};
        end
      end

      assign sync_o[b] = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/opmode_timer.sv
module opmode_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);

  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  // Count while running, clear when idle, hold at the last value
  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!run_i) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q != LAST) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/opmode_fsm.sv
module opmode_fsm
  import opmode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sup_hi,
  input  logic              sup_lo,
  input  logic              over_temp,
  input  logic              vout_uv,
  input  logic              uv_filt,
  input  logic              bus_wake,
  input  logic              en_s,
  input  logic              txd_s,
  input  logic              rst_done,
  input  logic              sel_done,
  output logic              in_reset,
  output logic              in_select,
  output logic              reg_en_o,
  output logic              rst_out_n,
  output logic [XCVR_W-1:0] xcvr_mode_o,
  output logic [MODE_W-1:0] mode_o
);

  state_e st_q;
  state_e st_d;
  state_e st_eff;
  logic   reg_on_state;

  assign reg_on_state = (st_q == ST_NORMAL) || (st_q == ST_SELECT) ||
                        (st_q == ST_STANDBY);

  // Next-state logic, highest priority first
  always_comb begin
    st_d = st_q;
    if (sup_lo) begin
      st_d = ST_SHDN;
    end else if (st_q == ST_SHDN) begin
      if (sup_hi && !over_temp) st_d = ST_RESET;
    end else if (over_temp) begin
      st_d = ST_THERM;
    end else if (uv_filt && reg_on_state) begin
      st_d = ST_RESET;
    end else begin
      unique case (st_q)
        ST_THERM:   st_d = ST_RESET;
        ST_RESET:   if (rst_done && !vout_uv) st_d = en_s ? ST_NORMAL : ST_STANDBY;
        ST_NORMAL:  if (!en_s) st_d = ST_SELECT;
        ST_SELECT: begin
          if (en_s)          st_d = ST_NORMAL;
          else if (sel_done) st_d = txd_s ? ST_STANDBY : ST_SLEEP;
        end
        ST_STANDBY: if (en_s) st_d = ST_NORMAL;
        ST_SLEEP:   if (bus_wake || en_s) st_d = ST_RESET;
        default:    st_d = ST_SHDN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_SHDN;
    end else begin
      st_q <= st_d;
    end
  end

  assign in_reset  = (st_q == ST_RESET);
  assign in_select = (st_q == ST_SELECT);

  // Supply loss overrides the outputs without waiting for a clock edge
  assign st_eff = sup_lo ? ST_SHDN : st_q;

  always_comb begin
    reg_en_o    = 1'b0;
    rst_out_n   = 1'b0;
    xcvr_mode_o = XC_OFF;
    mode_o      = MD_SHDN;
    unique case (st_eff)
      ST_SHDN: begin
        mode_o = MD_SHDN;
      end
      ST_RESET: begin
        reg_en_o    = 1'b1;
        xcvr_mode_o = XC_WAKE;
        mode_o      = MD_RESET;
      end
      ST_NORMAL: begin
        reg_en_o    = 1'b1;
        rst_out_n   = 1'b1;
        xcvr_mode_o = XC_ACTIVE;
        mode_o      = MD_NORMAL;
      end
      ST_SELECT: begin
        reg_en_o    = 1'b1;
        rst_out_n   = 1'b1;
        xcvr_mode_o = XC_WAKE;
        mode_o      = MD_NORMAL;
      end
      ST_STANDBY: begin
        reg_en_o    = 1'b1;
        rst_out_n   = 1'b1;
        xcvr_mode_o = XC_WAKE;
        mode_o      = MD_STANDBY;
      end
      ST_SLEEP: begin
        xcvr_mode_o = XC_WAKE;
        mode_o      = MD_SLEEP;
      end
      ST_THERM: begin
        xcvr_mode_o = XC_WAKE;
        mode_o      = MD_THERM;
      end
      default: begin
        mode_o = MD_SHDN;
      end
    endcase
  end

endmodule

// File: rtl/opmode_ctrl.sv
module opmode_ctrl
  import opmode_pkg::*;
#(
  parameter int unsigned RST_CYC = 250000,
  parameter int unsigned SEL_CYC = 1500,
  parameter int unsigned UVF_CYC = 1250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sup_hi,
  input  logic              sup_lo,
  input  logic              over_temp,
  input  logic              vout_uv,
  input  logic              bus_wake,
  input  logic              en,
  input  logic              txd,
  output logic              reg_en_o,
  output logic              rst_out_n,
  output logic [XCVR_W-1:0] xcvr_mode_o,
  output logic [MODE_W-1:0] mode_o
);

  localparam int unsigned PIN_W = 2;
  localparam int unsigned UVF_LIMIT = UVF_CYC + 1;

  logic [PIN_W-1:0] pins_s;
  logic             en_s;
  logic             txd_s;
  logic             in_reset;
  logic             in_select;
  logic             rst_done;
  logic             sel_done;
  logic             uv_filt;

  opmode_sync #(.WIDTH(PIN_W), .STAGES(2)) u_pin_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({txd, en}),
    .sync_o  (pins_s)
  );

  assign en_s  = pins_s[0];
  assign txd_s = pins_s[1];

  opmode_timer #(.LIMIT(RST_CYC)) u_rst_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (in_reset),
    .done_o (rst_done)
  );

  opmode_timer #(.LIMIT(SEL_CYC)) u_sel_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (in_select),
    .done_o (sel_done)
  );

  // Persistence filter: asserted after UVF_CYC consecutive low-output cycles
  opmode_timer #(.LIMIT(UVF_LIMIT)) u_uv_filt (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (vout_uv),
    .done_o (uv_filt)
  );

  opmode_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .sup_hi      (sup_hi),
    .sup_lo      (sup_lo),
    .over_temp   (over_temp),
    .vout_uv     (vout_uv),
    .uv_filt     (uv_filt),
    .bus_wake    (bus_wake),
    .en_s        (en_s),
    .txd_s       (txd_s),
    .rst_done    (rst_done),
    .sel_done    (sel_done),
    .in_reset    (in_reset),
    .in_select   (in_select),
    .reg_en_o    (reg_en_o),
    .rst_out_n   (rst_out_n),
    .xcvr_mode_o (xcvr_mode_o),
    .mode_o      (mode_o)
  );

endmodule

// File: rtl/opmode_ctrl_chk.sv
module opmode_ctrl_chk
  import opmode_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sup_hi,
  input logic              sup_lo,
  input logic              over_temp,
  input logic              vout_uv,
  input logic              bus_wake,
  input logic              reg_en_o,
  input logic              rst_out_n,
  input logic [XCVR_W-1:0] xcvr_mode_o,
  input logic [MODE_W-1:0] mode_o
);

  AST_SHDN_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    sup_lo |-> (mode_o == MD_SHDN && !reg_en_o && !rst_out_n && xcvr_mode_o == XC_OFF)); // R2

  AST_SHDN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MD_SHDN && !(sup_hi && !over_temp)) |=> (mode_o == MD_SHDN)); // R3

  AST_SHDN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MD_SHDN) |=> (mode_o == MD_SHDN || mode_o == MD_RESET)); // R3

  AST_THERM_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (over_temp && !sup_lo && mode_o != MD_SHDN) |=> (mode_o == MD_THERM || mode_o == MD_SHDN)); // R4

  AST_THERM_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MD_THERM) |-> (!reg_en_o && !rst_out_n && xcvr_mode_o == XC_WAKE)); // R4

  AST_RESET_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MD_RESET) |-> (reg_en_o && !rst_out_n)); // R5

  AST_RESET_HELD_LOW_VOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MD_RESET && vout_uv && !sup_lo && !over_temp) |=> (mode_o == MD_RESET || mode_o == MD_SHDN)); // R5

  AST_SLEEP_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MD_SLEEP && bus_wake && !sup_lo && !over_temp) |=> (mode_o == MD_RESET || mode_o == MD_SHDN)); // R11

  AST_RELEASE_NEEDS_REG: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out_n |-> reg_en_o); // R10

endmodule

bind opmode_ctrl opmode_ctrl_chk chk_i (.*);

// File: tb/opmode_ctrl_tb.sv
module opmode_ctrl_tb_top;

  localparam int unsigned RST = 20;
  localparam int unsigned SEL = 8;
  localparam int unsigned UVF = 6;

  logic       clk = 1'b0;
  logic       rst_n, sup_hi, sup_lo, over_temp, vout_uv, bus_wake, en, txd;
  logic       reg_en_o, rst_out_n;
  logic [1:0] xcvr_mode_o;
  logic [2:0] mode_o;

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  typedef struct {
    logic [2:0] mode;
    logic [1:0] xc;
    string      tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  event     sb_ev;

  always #10 clk = ~clk;

  opmode_ctrl #(.RST_CYC(RST), .SEL_CYC(SEL), .UVF_CYC(UVF)) dut_i (
    .clk(clk), .rst_n(rst_n), .sup_hi(sup_hi), .sup_lo(sup_lo),
    .over_temp(over_temp), .vout_uv(vout_uv), .bus_wake(bus_wake),
    .en(en), .txd(txd), .reg_en_o(reg_en_o), .rst_out_n(rst_out_n),
    .xcvr_mode_o(xcvr_mode_o), .mode_o(mode_o)
  );

  function automatic logic [1:0] xc_of(input logic [2:0] m);
    if (m == 3'd0) return 2'd0;
    if (m == 3'd2) return 2'd2;
    return 2'd1;
  endfunction

  task automatic wait_n(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic expect_st(input logic [2:0] m, input logic [1:0] x, input string tag);
    sb_item_t it;
    it.mode = m;
    it.xc   = x;
    it.tag  = tag;
    sb_q.push_back(it);
    ->sb_ev;
    #1;
  endtask

  task automatic expect_m(input logic [2:0] m, input string tag);
    expect_st(m, xc_of(m), tag);
  endtask

  // Monitor: pops expected items and compares them with the outputs
  initial begin
    forever begin
      @(sb_ev);
      while (sb_q.size() != 0) begin
        sb_item_t it;
        logic     er, erst;
        it   = sb_q.pop_front();
        er   = (it.mode == 3'd1) || (it.mode == 3'd2) || (it.mode == 3'd3);
        erst = (it.mode == 3'd2) || (it.mode == 3'd3);
        nchk++;
        if (mode_o !== it.mode || reg_en_o !== er || rst_out_n !== erst ||
            xcvr_mode_o !== it.xc) begin
          nerr++;
          $display("FAIL %s: got mode=%0d reg=%0b rst=%0b xcvr=%0d, expected mode=%0d reg=%0b rst=%0b xcvr=%0d",
                   it.tag, mode_o, reg_en_o, rst_out_n, xcvr_mode_o,
                   it.mode, er, erst, it.xc);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog: got timeout, expected end of sequence");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    rst_n = 0; sup_hi = 0; sup_lo = 1; over_temp = 0; vout_uv = 1;
    bus_wake = 0; en = 0; txd = 1;
    wait_n(3);
    expect_m(3'd0, "R1 state after logic reset");
    rst_n = 1;
    wait_n(2);
    sup_lo = 0;
    wait_n(3);
    expect_m(3'd0, "R3 hold without power-up level");
    sup_hi = 1; over_temp = 1;
    wait_n(3);
    expect_m(3'd0, "R3 hold while hot, no thermal from shutdown");
    over_temp = 0;
    wait_n(1);
    expect_m(3'd1, "R3 exit to reset");
    wait_n(30);
    expect_m(3'd1, "R5 reset extended by low regulator output");
    vout_uv = 0;
    wait_n(1);
    expect_m(3'd3, "R6 reset exit with enable low to standby");

    en = 1;
    wait_n(2);
    expect_m(3'd3, "R7 no effect two edges after enable");
    wait_n(1);
    expect_m(3'd2, "R10 standby to normal on enable");

    txd = 1; en = 0;
    wait_n(3);
    expect_st(3'd2, 2'd1, "R8 window opens, transmitter blocked");
    wait_n(SEL - 1);
    expect_st(3'd2, 2'd1, "R8 window still open");
    wait_n(1);
    expect_m(3'd3, "R8 transmit-data high selects standby");

    en = 1;
    wait_n(3);
    expect_m(3'd2, "R10 back to normal");
    txd = 1; en = 0;
    wait_n(3);
    txd = 0;
    wait_n(SEL);
    expect_m(3'd4, "R8 late transmit-data low selects sleep");

    vout_uv = 1;
    wait_n(UVF + 5);
    expect_m(3'd4, "R11 undervoltage ignored in sleep");
    bus_wake = 1; vout_uv = 0;
    wait_n(1);
    expect_m(3'd1, "R11 bus wakeup enters reset");
    bus_wake = 0;
    wait_n(RST - 1);
    expect_m(3'd1, "R5 reset lasts its full length");
    wait_n(1);
    expect_m(3'd3, "R5 reset ends after exact length");

    en = 1; txd = 1;
    wait_n(3);
    en = 0; txd = 0;
    wait_n(3 + SEL);
    expect_m(3'd4, "R8 sleep selected again");
    en = 1;
    wait_n(2);
    expect_m(3'd4, "R7 sleep held during sync latency");
    wait_n(1);
    expect_m(3'd1, "R11 enable wakes sleep into reset");
    wait_n(RST);
    expect_m(3'd2, "R6 reset exit with enable high to normal");

    en = 0;
    wait_n(4);
    en = 1;
    wait_n(SEL + 4);
    expect_st(3'd2, 2'd2, "R9 window aborted, active again");

    vout_uv = 1;
    wait_n(UVF - 1);
    vout_uv = 0;
    wait_n(3);
    expect_m(3'd2, "R12 short dip ignored");
    vout_uv = 1;
    wait_n(UVF);
    expect_m(3'd2, "R12 filter not yet elapsed");
    wait_n(1);
    expect_m(3'd1, "R12 filtered undervoltage forces reset");
    vout_uv = 0;
    wait_n(RST + 2);
    expect_m(3'd2, "R6 normal after undervoltage reset");

    over_temp = 1;
    wait_n(1);
    expect_m(3'd5, "R4 over-temperature enters thermal");
    vout_uv = 1;
    wait_n(5);
    expect_m(3'd5, "R4 thermal held while hot");
    over_temp = 0;
    wait_n(1);
    expect_m(3'd1, "R4 cool down enters reset");
    vout_uv = 0;
    wait_n(RST + 2);
    expect_m(3'd2, "R6 normal after thermal");

    sup_lo = 1;
    #2;
    expect_m(3'd0, "R2 immediate shutdown outputs");
    sup_hi = 0;
    wait_n(1);
    sup_lo = 0; over_temp = 1;
    wait_n(3);
    expect_m(3'd0, "R2 shutdown latched and over thermal");
    over_temp = 0; sup_hi = 1;
    wait_n(1);
    expect_m(3'd1, "R3 power-up leaves shutdown to reset");

    wait_n(2);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule